// File: doc/BRIEF.md
# Frame Skip Controller

This block sits between the video capture path and the encoder core. It decides for every incoming frame whether the encoder processes it or skips it. It also marks each processed frame as an intra picture or a predicted picture. The keep ratio comes from a two-bit rate code and a one-bit input-family select. The 30 fps family (also used for 29.97 fps interlaced input) keeps one frame in 1, 2, 30 or 60. The 25 fps family keeps one frame in 1, 2, 25 or 50.

The host can pause encoding and resume it later. A resume starts a fresh decimation interval, clears the frame statistics and forces the next processed frame to be intra, so that a decoder can lock on again.

A separate watchdog counts system clocks since the last frame start. It raises a sticky camera-fault flag when that count reaches a programmable limit. The flag stays set until the host clears it.

Top module: `frame_skip_ctrl`

## Requirements
- R1: After reset, encStrobe, isIntra, suspended and camFault are 0, statusWord is 0, and the first accepted frame is kept as an intra picture.
- R2: The keep divisor is chosen by {stdSel, rateSel}. With stdSel=0, rateSel 0/1/2/3 gives 1/2/30/60. With stdSel=1 it gives 1/2/25/50. The first accepted frame of an interval is kept and the next divisor-1 accepted frames are dropped.
- R3: A kept frame produces a one-cycle encStrobe on the clock after the edge that samples its frameStart. encStrobe never rises without frameStart on the previous cycle.
- R4: rateSel and stdSel are sampled only when a frame is kept. A code change during an interval does not shorten or lengthen that interval.
- R5: When allIntra=1 at the kept frame, isIntra is 1. In predicted mode (allIntra=0), only the first kept frame after reset or restart has isIntra=1. isIntra is 0 whenever encStrobe is 0.
- R6: A suspendReq pulse sets suspended on the next cycle. While suspended, frames are neither kept nor counted.
- R7: A restartReq pulse clears suspended, the decimation interval and both counters on the next cycle, and the next kept frame is intra. restartReq wins over a simultaneous suspendReq.
- R8: A frameStart in the same cycle as suspendReq or restartReq is ignored: it is not kept, not dropped and not counted.
- R9: With camTimeout=T>0, camFault sets on the edge at which T clocks have passed without a frameStart. T=0 disables the watchdog.
- R10: camFault stays set until camClear. In the cycle camClear is high, the clear wins over a new set.
- R11: statusWord holds {kept count, dropped count}, each CNT_W bits with the kept count in the upper half. Both count only accepted frames and saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse at the start of each captured frame |
| stdSel | input | 1 | Input family: 0 = 30/29.97 fps, 1 = 25 fps |
| rateSel | input | 2 | Output rate code, 0 = full rate up to 3 = slowest |
| allIntra | input | 1 | 1 = every kept frame intra, 0 = intra then predicted |
| suspendReq | input | 1 | Host pulse that pauses encoding |
| restartReq | input | 1 | Host pulse that resumes encoding with a fresh interval |
| camTimeout | input | TO_W | Watchdog limit in clocks, 0 disables |
| camClear | input | 1 | Host clear of the camera fault flag |
| encStrobe | output | 1 | One-cycle pulse: encode this frame |
| isIntra | output | 1 | Picture type of the strobed frame, 1 = intra |
| suspended | output | 1 | Encoding is paused |
| camFault | output | 1 | Sticky camera-input abnormality flag |
| statusWord | output | 2*CNT_W | {kept count, dropped count} since restart |

## Verification
The bound checker watches the relations that hold on every cycle:
- a strobe always follows a frame start;
- nothing is strobed while paused;
- the picture-type flag appears only with a strobe and is intra whenever all-intra was selected;
- a suspend request takes effect, and a restart request clears the state;
- the fault flag stays set until cleared, the clear wins, and a zero limit never raises it;
- the counters never decrease between restarts.

Only the bench scenarios can show the actual decimation ratios for both families. They also show that a mid-interval rate change is deferred, that predicted mode yields exactly one intra frame per restart, that frames arriving with a host request are ignored, that the counters saturate, and the exact clock on which the watchdog fires.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic keep;     // accepted frame at an interval boundary
    logic drop;     // accepted frame inside an interval
    logic restart;  // fresh interval and statistics
  } fskStrobe_t;
endpackage

// File: rtl/fsk_control.sv
module fsk_control
  import fsk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       suspendReq,
  input  logic       restartReq,
  input  logic       allIntra,
  input  logic       phaseZero,
  output fskStrobe_t stb,
  output logic       encStrobe,
  output logic       isIntra,
  output logic       suspended
);
  logic suspendedQ;
  logic forceIntraQ;
  logic frameOk;

  // Frames coinciding with a host request are ignored
  assign frameOk     = frameStart & ~suspendReq & ~restartReq & ~suspendedQ;
  assign stb.keep    = frameOk & phaseZero;
  assign stb.drop    = frameOk & ~phaseZero;
  assign stb.restart = restartReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspendedQ <= 1'b0;
    end else if (restartReq) begin
      suspendedQ <= 1'b0;
    end else if (suspendReq) begin
      suspendedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceIntraQ <= 1'b1;
    end else if (restartReq) begin
      forceIntraQ <= 1'b1;
    end else if (stb.keep) begin
      forceIntraQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encStrobe <= 1'b0;
      isIntra   <= 1'b0;
    end else begin
      encStrobe <= stb.keep;
      isIntra   <= stb.keep & (allIntra | forceIntraQ);
    end
  end

  assign suspended = suspendedQ;
endmodule

// File: rtl/fsk_datapath.sv
module fsk_datapath
  import fsk_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DIV0_SLOW     = 30,
  parameter int DIV0_SLOWEST  = 60,
  parameter int DIV1_SLOW     = 25,
  parameter int DIV1_SLOWEST  = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  fskStrobe_t         stb,
  input  logic               stdSel,
  input  logic [1:0]         rateSel,
  output logic               phaseZero,
  output logic [2*CNT_W-1:0] statusWord
);
  localparam int DIV_MAX = (DIV0_SLOWEST > DIV1_SLOWEST) ? DIV0_SLOWEST : DIV1_SLOWEST;
  localparam int PH_W    = $clog2(DIV_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PH_W-1:0]  phaseQ;
  logic [PH_W-1:0]  divSel;
  logic [CNT_W-1:0] passQ;
  logic [CNT_W-1:0] dropQ;

  // Divisor lookup, sampled only when a frame is kept
  always_comb begin
    unique case (rateSel)
      2'd0:    divSel = PH_W'(1);
      2'd1:    divSel = PH_W'(2);
      2'd2:    divSel = stdSel ? PH_W'(DIV1_SLOW)    : PH_W'(DIV0_SLOW);
      default: divSel = stdSel ? PH_W'(DIV1_SLOWEST) : PH_W'(DIV0_SLOWEST);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.restart) begin
      phaseQ <= '0;
    end else if (stb.keep) begin
      phaseQ <= divSel - PH_W'(1);
    end else if (stb.drop) begin
      phaseQ <= phaseQ - PH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.restart) begin
      passQ <= '0;
      dropQ <= '0;
    end else begin
      if (stb.keep && passQ != CNT_MAX) passQ <= passQ + CNT_W'(1);
      if (stb.drop && dropQ != CNT_MAX) dropQ <= dropQ + CNT_W'(1);
    end
  end

  assign phaseZero  = (phaseQ == '0);
  assign statusWord = {passQ, dropQ};
endmodule

// File: rtl/fsk_camwatch.sv
module fsk_camwatch #(
  parameter int TO_W = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStart,
  input  logic [TO_W-1:0] camTimeout,
  input  logic            camClear,
  output logic            camFault
);
  localparam logic [TO_W-1:0] IDLE_MAX = '1;

  logic [TO_W-1:0] idleQ;
  logic            expired;

  assign expired = (camTimeout != '0) && (idleQ >= camTimeout);

  always_ff @(posedge clk) begin
    if (!rstN || frameStart) begin
      idleQ <= '0;
    end else if (idleQ != IDLE_MAX) begin
      idleQ <= idleQ + TO_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || camClear) begin
      camFault <= 1'b0;
    end else if (expired) begin
      camFault <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_skip_ctrl.sv
module frame_skip_ctrl
  import fsk_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int TO_W          = 24,
  parameter int DIV0_SLOW     = 30,
  parameter int DIV0_SLOWEST  = 60,
  parameter int DIV1_SLOW     = 25,
  parameter int DIV1_SLOWEST  = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               stdSel,
  input  logic [1:0]         rateSel,
  input  logic               allIntra,
  input  logic               suspendReq,
  input  logic               restartReq,
  input  logic [TO_W-1:0]    camTimeout,
  input  logic               camClear,
  output logic               encStrobe,
  output logic               isIntra,
  output logic               suspended,
  output logic               camFault,
  output logic [2*CNT_W-1:0] statusWord
);
  fskStrobe_t stb;
  logic       phaseZero;

  fsk_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .suspendReq (suspendReq),
    .restartReq (restartReq),
    .allIntra   (allIntra),
    .phaseZero  (phaseZero),
    .stb        (stb),
    .encStrobe  (encStrobe),
    .isIntra    (isIntra),
    .suspended  (suspended)
  );

  fsk_datapath #(
    .CNT_W        (CNT_W),
    .DIV0_SLOW    (DIV0_SLOW),
    .DIV0_SLOWEST (DIV0_SLOWEST),
    .DIV1_SLOW    (DIV1_SLOW),
    .DIV1_SLOWEST (DIV1_SLOWEST)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .stdSel     (stdSel),
    .rateSel    (rateSel),
    .phaseZero  (phaseZero),
    .statusWord (statusWord)
  );

  fsk_camwatch #(
    .TO_W (TO_W)
  ) u_camwatch (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .camTimeout (camTimeout),
    .camClear   (camClear),
    .camFault   (camFault)
  );
endmodule

// File: rtl/frame_skip_ctrl_chk.sv
module frame_skip_ctrl_chk #(
  parameter int CNT_W = 16,
  parameter int TO_W  = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameStart,
  input logic               allIntra,
  input logic               suspendReq,
  input logic               restartReq,
  input logic [TO_W-1:0]    camTimeout,
  input logic               camClear,
  input logic               encStrobe,
  input logic               isIntra,
  input logic               suspended,
  input logic               camFault,
  input logic [2*CNT_W-1:0] statusWord
);
  logic [CNT_W-1:0] passCnt;
  logic [CNT_W-1:0] dropCnt;
  assign passCnt = statusWord[2*CNT_W-1:CNT_W];
  assign dropCnt = statusWord[CNT_W-1:0];

  assert_strobe_after_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    encStrobe |-> $past(frameStart));

  assert_single_cycle_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    encStrobe |=> !encStrobe);

  assert_intra_only_with_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    isIntra |-> encStrobe);

  assert_all_intra_R5: assert property (@(posedge clk) disable iff (!rstN)
    (encStrobe && $past(allIntra)) |-> isIntra);

  assert_suspend_takes_effect_R6: assert property (@(posedge clk) disable iff (!rstN)
    (suspendReq && !restartReq) |=> suspended);

  assert_quiet_when_suspended_R6: assert property (@(posedge clk) disable iff (!rstN)
    suspended |=> !encStrobe);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> (!suspended && statusWord == '0));

  assert_timeout_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (camTimeout == '0 && !camFault) |=> !camFault);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (camFault && !camClear) |=> camFault);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    camClear |=> !camFault);

  assert_counts_monotonic_R11: assert property (@(posedge clk) disable iff (!rstN)
    !restartReq |=> (passCnt >= $past(passCnt) && dropCnt >= $past(dropCnt)));
endmodule

bind frame_skip_ctrl frame_skip_ctrl_chk #(.CNT_W(CNT_W), .TO_W(TO_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .allIntra   (allIntra),
  .suspendReq (suspendReq),
  .restartReq (restartReq),
  .camTimeout (camTimeout),
  .camClear   (camClear),
  .encStrobe  (encStrobe),
  .isIntra    (isIntra),
  .suspended  (suspended),
  .camFault   (camFault),
  .statusWord (statusWord)
);

// File: tb/frame_skip_ctrl_tb.sv
`timescale 1ns/1ps
module frame_skip_ctrl_tb;
  localparam int CNT_W = 6;
  localparam int TO_W  = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int IMAX  = (1 << TO_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, stdSel = 1'b0, allIntra = 1'b0;
  logic suspendReq = 1'b0, restartReq = 1'b0, camClear = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic [TO_W-1:0] camTimeout = 8'd20;
  logic encStrobe, isIntra, suspended, camFault;
  logic [2*CNT_W-1:0] statusWord;

  int checks = 0, failures = 0;
  int pulseTot = 0, intraTot = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frame_skip_ctrl #(.CNT_W(CNT_W), .TO_W(TO_W)) u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .stdSel(stdSel),
    .rateSel(rateSel), .allIntra(allIntra), .suspendReq(suspendReq),
    .restartReq(restartReq), .camTimeout(camTimeout), .camClear(camClear),
    .encStrobe(encStrobe), .isIntra(isIntra), .suspended(suspended),
    .camFault(camFault), .statusWord(statusWord)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int mSusp, mForce, mPhase, mPass, mDrop, mIdle, mFault, mEnc, mIntra;

  function automatic int divisorOf(input int fam, input int code);
    int d;
    case (code)
      0: d = 1;
      1: d = 2;
      2: d = fam ? 25 : 30;
      default: d = fam ? 50 : 60;
    endcase
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSusp = 0; mForce = 1; mPhase = 0; mPass = 0; mDrop = 0;
      mIdle = 0; mFault = 0; mEnc = 0; mIntra = 0;
    end else begin
      bit accept, keepIt, dropIt;
      accept = frameStart && !suspendReq && !restartReq && (mSusp == 0);
      keepIt = accept && (mPhase == 0);
      dropIt = accept && (mPhase != 0);
      mEnc   = keepIt;
      mIntra = keepIt && (allIntra || mForce != 0);
      if (restartReq) begin
        mPhase = 0; mPass = 0; mDrop = 0; mForce = 1; mSusp = 0;
      end else begin
        if (keepIt) begin
          mPhase = divisorOf(stdSel, rateSel) - 1;
          mForce = 0;
          if (mPass < CMAX) mPass++;
        end else if (dropIt) begin
          mPhase--;
          if (mDrop < CMAX) mDrop++;
        end
        if (suspendReq) mSusp = 1;
      end
      if (camClear) mFault = 0;
      else if (camTimeout != 0 && mIdle >= camTimeout) mFault = 1;
      if (frameStart) mIdle = 0;
      else if (mIdle < IMAX) mIdle++;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(encStrobe == mEnc,   "R3 encStrobe", encStrobe, mEnc);
      check(isIntra == mIntra,   "R5 isIntra", isIntra, mIntra);
      check(suspended == mSusp,  "R6 suspended", suspended, mSusp);
      check(camFault == mFault,  "R9 camFault", camFault, mFault);
      check(statusWord[2*CNT_W-1:CNT_W] == mPass, "R11 kept count",
            statusWord[2*CNT_W-1:CNT_W], mPass);
      check(statusWord[CNT_W-1:0] == mDrop, "R11 dropped count",
            statusWord[CNT_W-1:0], mDrop);
      if (encStrobe) pulseTot++;
      if (isIntra) intraTot++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frameStart = 1'b1; tick(1);
      frameStart = 1'b0; tick(3);
    end
  endtask

  task automatic restart();
    restartReq = 1'b1; tick(1);
    restartReq = 1'b0; tick(1);
  endtask

  task automatic expectPulses(input int n, input int exp, input string tag);
    int base;
    base = pulseTot;
    frames(n);
    check(pulseTot - base == exp, tag, pulseTot - base, exp);
  endtask

  initial begin
    int p0, i0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check(encStrobe == 0 && isIntra == 0 && suspended == 0 && camFault == 0,
          "R1 reset outputs", {encStrobe, isIntra, suspended, camFault}, 0);
    check(statusWord == 0, "R1 reset status", statusWord, 0);

    // R2/R5 full rate, predicted mode
    p0 = pulseTot; i0 = intraTot;
    frames(5);
    check(pulseTot - p0 == 5, "R2 full rate", pulseTot - p0, 5);
    check(intraTot - i0 == 1, "R5 one intra in predicted mode", intraTot - i0, 1);

    // R2 divisor table, both families
    rateSel = 2'd1; restart();
    expectPulses(10, 5, "R2 half rate");
    check(statusWord[CNT_W-1:0] == 5, "R11 dropped after half rate", statusWord[CNT_W-1:0], 5);
    rateSel = 2'd2; restart();
    expectPulses(60, 2, "R2 family0 divisor 30");
    rateSel = 2'd3; restart();
    expectPulses(120, 2, "R2 family0 divisor 60");
    check(statusWord[CNT_W-1:0] == CMAX, "R11 dropped count saturates",
          statusWord[CNT_W-1:0], CMAX);
    stdSel = 1'b1; rateSel = 2'd2; restart();
    expectPulses(50, 2, "R2 family1 divisor 25");
    rateSel = 2'd3; restart();
    expectPulses(100, 2, "R2 family1 divisor 50");

    // R4 rate change deferred to the next kept frame
    stdSel = 1'b0; rateSel = 2'd3; restart();
    expectPulses(10, 1, "R4 first interval start");
    rateSel = 2'd0;
    expectPulses(50, 0, "R4 interval not shortened");
    expectPulses(4, 4, "R4 new rate after boundary");

    // R5 all-intra, then back to predicted
    allIntra = 1'b1; restart();
    i0 = intraTot;
    frames(4);
    check(intraTot - i0 == 4, "R5 all intra", intraTot - i0, 4);
    allIntra = 1'b0; i0 = intraTot;
    frames(3);
    check(intraTot - i0 == 0, "R5 predicted after intra", intraTot - i0, 0);
    // R7 restart forces intra
    restart(); i0 = intraTot;
    frames(2);
    check(intraTot - i0 == 1, "R7 intra after restart", intraTot - i0, 1);

    // R6 suspend
    suspendReq = 1'b1; tick(1); suspendReq = 1'b0;
    check(suspended == 1, "R6 suspended set", suspended, 1);
    p0 = statusWord;
    expectPulses(5, 0, "R6 no strobes while suspended");
    check(statusWord == p0, "R6 no counting while suspended", statusWord, p0);
    restart();
    check(suspended == 0, "R7 suspended cleared", suspended, 0);
    i0 = intraTot;
    expectPulses(1, 1, "R7 frame kept after restart");
    check(intraTot - i0 == 1, "R7 kept frame intra", intraTot - i0, 1);

    // R7 restart wins over simultaneous suspend
    suspendReq = 1'b1; restartReq = 1'b1; tick(1);
    suspendReq = 1'b0; restartReq = 1'b0; tick(1);
    check(suspended == 0, "R7 restart priority", suspended, 1'b0);

    // R8 frame with a host request is ignored
    frames(2);
    p0 = statusWord;
    frameStart = 1'b1; suspendReq = 1'b1; tick(1);
    frameStart = 1'b0; suspendReq = 1'b0; tick(2);
    check(statusWord == p0, "R8 frame with suspend ignored", statusWord, p0);
    frameStart = 1'b1; restartReq = 1'b1; tick(1);
    frameStart = 1'b0; restartReq = 1'b0; tick(2);
    check(statusWord == 0, "R8 frame with restart ignored", statusWord, 0);

    // R9 watchdog, T=20
    tick(15);
    check(camFault == 0, "R9 no fault before limit", camFault, 0);
    tick(20);
    check(camFault == 1, "R9 fault after limit", camFault, 1);
    tick(50);
    check(camFault == 1, "R10 fault sticky", camFault, 1);
    frames(1);
    camClear = 1'b1; tick(1); camClear = 1'b0;
    check(camFault == 0, "R10 cleared", camFault, 0);
    frames(10);
    check(camFault == 0, "R9 regular frames no fault", camFault, 0);

    // R10 clear wins while condition holds
    camTimeout = 8'd5; tick(20);
    check(camFault == 1, "R9 short limit fault", camFault, 1);
    camClear = 1'b1; tick(3);
    check(camFault == 0, "R10 clear wins", camFault, 0);
    camClear = 1'b0; tick(2);
    check(camFault == 1, "R10 re-set after clear", camFault, 1);

    // R9 zero limit disables
    camTimeout = 8'd0;
    camClear = 1'b1; tick(1); camClear = 1'b0;
    tick(300);
    check(camFault == 0, "R9 zero limit disabled", camFault, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule